// File: doc/BRIEF.md
# Always-On Seconds Counter with Alarm

This block is a real-time clock meant for an always-on power region. A 47-bit counter advances by one on each slow-clock tick. The slow clock is modelled as a single-cycle enable strobe inside the main clock domain. The top 32 counter bits count whole seconds and the bottom 15 bits count fractions of a second. A 32-bit seconds target can raise a sticky alarm flag and an interrupt.

Software reaches the block through a plain 32-bit register port with word-aligned byte offsets. Writes take one clock edge and reads return data combinationally. Enable bits written to the control register do not act at once. They pass through a pipeline that shifts only on ticks, and the control readback shows the synchronized value. Software therefore polls until the readback matches what it wrote. The counter can only be loaded while it is effectively stopped. A general 32-bit scratch register is also provided; firmware stores a fixed pattern in it at start-up.

Top module: `lp_rtc`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: Offset 0x20 reads counter bits 31:0. Offset 0x1C reads counter bits 46:32 in bits 14:0, with bits 31:15 reading zero. A write to 0x1C keeps only wdata bits 14:0.
- R3: Writes to 0x20 and 0x1C load the counter only while the synchronized run bit is 0. While that bit is 1, such writes are ignored.
- R4: While the synchronized run bit is 1, the counter rises by exactly one on each tick. Otherwise it holds its value.
- R5: The control register is at offset 0x04. Bit 0 is run, bit 1 is alarm enable and bit 3 is wake enable. A written value becomes effective, and visible on readback, at the edge of the third tick after the write. Bit 2 and bits 31:4 read zero.
- R6: Status bit 0 at offset 0x18 is the alarm flag. It sets on a tick where counter bits 46:15 equal the target at offset 0x24, but only while the synchronized alarm enable is 1.
- R7: The alarm flag stays set until software writes status with bit 0 set. Writing status with bit 0 clear leaves the flag as it is.
- R8: `irq` equals the alarm flag ANDed with the synchronized alarm enable and the synchronized wake enable.
- R9: Offset 0x30 is a 32-bit read/write scratch register.
- R10: Offsets outside the map read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Slow-clock enable strobe, one cycle wide |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 8 | Byte offset, shared by reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq | output | 1 | Alarm interrupt |

## Verification
The hardest case to reach is the alarm firing on the exact tick. To get there, the counter is first stopped through the synchronizer. It is then preloaded two ticks short of the target second, and run, alarm enable and wake enable are all turned on together. The bench then counts ticks one at a time to find the edge where the flag appears. It then removes wake enable, checks that the flag stays but the interrupt drops, and clears the flag between ticks. It also checks that loads are ignored while running and that the control readback lags the write by three ticks.

// File: rtl/lp_rtc_pkg.sv
package lp_rtc_pkg;
  localparam logic [7:0] OFF_CTRL  = 8'h04;
  localparam logic [7:0] OFF_STAT  = 8'h18;
  localparam logic [7:0] OFF_CNTH  = 8'h1C;
  localparam logic [7:0] OFF_CNTL  = 8'h20;
  localparam logic [7:0] OFF_ALRM  = 8'h24;
  localparam logic [7:0] OFF_SPARE = 8'h30;

  localparam int CTRL_W = 4;

  typedef struct packed {
    logic wake;
    logic rsv;
    logic alm;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/lp_rtc_sync.sv
module lp_rtc_sync #(
  parameter int STAGES = 3,
  parameter int W      = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe_q [STAGES];
  logic [W-1:0] pipe_d [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_comb pipe_d[g] = tick ? d : pipe_q[g];
    end else begin : g_rest
      always_comb pipe_d[g] = tick ? pipe_q[g-1] : pipe_q[g];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe_q[g] <= '0;
      else        pipe_q[g] <= pipe_d[g];
    end
  end

  assign q = pipe_q[STAGES-1];

  // R5: effective control only moves on a slow tick
  p_sync_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(q));
endmodule

// File: rtl/lp_rtc_counter.sv
module lp_rtc_counter #(
  parameter int CNT_W = 47
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic [31:0]      wdata,
  output logic [CNT_W-1:0] cnt
);
  localparam int HI_W = CNT_W - 32;

  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt;
    if (run) begin
      if (tick) cnt_d = cnt + 1'b1;
    end else begin
      if (wr_lo) cnt_d[31:0]       = wdata;
      if (wr_hi) cnt_d[CNT_W-1:32] = wdata[HI_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    run && tick |=> cnt == $past(cnt) + 1'b1);
  p_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    run && !tick |=> $stable(cnt));
endmodule

// File: rtl/lp_rtc_alarm.sv
module lp_rtc_alarm #(
  parameter int SEC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             alm_en,
  input  logic             wake_en,
  input  logic [SEC_W-1:0] secs,
  input  logic             tgt_wr,
  input  logic [SEC_W-1:0] wdata,
  input  logic             clr,
  output logic [SEC_W-1:0] tgt,
  output logic             flag,
  output logic             irq
);
  logic [SEC_W-1:0] tgt_d;
  logic             flag_d;
  logic             hit;

  always_comb begin
    hit    = tick && alm_en && (secs == tgt);
    flag_d = hit || (flag && !clr);
    tgt_d  = tgt_wr ? wdata : tgt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt  <= '0;
      flag <= 1'b0;
    end else begin
      tgt  <= tgt_d;
      flag <= flag_d;
    end
  end

  assign irq = flag && alm_en && wake_en;

  p_rise_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(tick) && $past(alm_en));
  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flag && !clr |=> flag);
endmodule

// File: rtl/lp_rtc.sv
module lp_rtc
  import lp_rtc_pkg::*;
#(
  parameter int CNT_W      = 47,
  parameter int FRAC_W     = 15,
  parameter int SYNC_TICKS = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        bus_wr,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq
);
  localparam int SEC_W = CNT_W - FRAC_W;
  localparam int HI_W  = CNT_W - 32;

  ctrl_t            ctrl_req, ctrl_req_d, ctrl_eff;
  logic [31:0]      spare, spare_d;
  logic [CNT_W-1:0] cnt;
  logic [SEC_W-1:0] tgt;
  logic             flag;
  logic             wr_ctrl, wr_stat, wr_lo, wr_hi, wr_alrm, wr_spare;

  always_comb begin
    wr_ctrl  = bus_wr && (bus_addr == OFF_CTRL);
    wr_stat  = bus_wr && (bus_addr == OFF_STAT);
    wr_lo    = bus_wr && (bus_addr == OFF_CNTL);
    wr_hi    = bus_wr && (bus_addr == OFF_CNTH);
    wr_alrm  = bus_wr && (bus_addr == OFF_ALRM);
    wr_spare = bus_wr && (bus_addr == OFF_SPARE);
    ctrl_req_d = ctrl_req;
    if (wr_ctrl) begin
      ctrl_req_d      = ctrl_t'(bus_wdata[CTRL_W-1:0]);
      ctrl_req_d.rsv  = 1'b0;
    end
    spare_d = wr_spare ? bus_wdata : spare;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_req <= '0;
      spare    <= '0;
    end else begin
      ctrl_req <= ctrl_req_d;
      spare    <= spare_d;
    end
  end

  lp_rtc_sync #(.STAGES(SYNC_TICKS), .W(CTRL_W)) u_sync (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .d(ctrl_req), .q(ctrl_eff)
  );

  lp_rtc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run(ctrl_eff.run),
    .wr_lo(wr_lo), .wr_hi(wr_hi), .wdata(bus_wdata), .cnt(cnt)
  );

  lp_rtc_alarm #(.SEC_W(SEC_W)) u_alm (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .alm_en(ctrl_eff.alm), .wake_en(ctrl_eff.wake),
    .secs(cnt[CNT_W-1:FRAC_W]), .tgt_wr(wr_alrm),
    .wdata(bus_wdata[SEC_W-1:0]), .clr(wr_stat && bus_wdata[0]),
    .tgt(tgt), .flag(flag), .irq(irq)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFF_CTRL:  bus_rdata[CTRL_W-1:0] = ctrl_eff;
      OFF_STAT:  bus_rdata[0]          = flag;
      OFF_CNTH:  bus_rdata[HI_W-1:0]   = cnt[CNT_W-1:32];
      OFF_CNTL:  bus_rdata             = cnt[31:0];
      OFF_ALRM:  bus_rdata[SEC_W-1:0]  = tgt;
      OFF_SPARE: bus_rdata             = spare;
      default:   bus_rdata = '0;
    endcase
  end

  // R8: no interrupt without the synchronized wake enable
  p_irq_wake_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ctrl_eff.wake && flag);
  // R9: scratch register only changes on its own write
  p_spare_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_spare |=> $stable(spare));
endmodule

// File: tb/sim_lp_rtc.sv
module sim_lp_rtc;
  localparam time PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  lp_rtc u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    bus_addr = a;
    #1;
    check(req, bus_rdata, exp);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic t_reset;
    rd_chk("R1 ctrl", 8'h04, 0);
    rd_chk("R1 stat", 8'h18, 0);
    rd_chk("R1 cntl", 8'h20, 0);
    rd_chk("R1 cnth", 8'h1C, 0);
    rd_chk("R1 alrm", 8'h24, 0);
    rd_chk("R1 spare", 8'h30, 0);
    check("R1 irq", {31'd0, irq}, 0);
  endtask

  task automatic t_spare;
    wr(8'h30, 32'h41736166);
    rd_chk("R9 spare", 8'h30, 32'h41736166);
    rd_chk("R10 hole 0x08", 8'h08, 0);
    rd_chk("R10 hole 0x00", 8'h00, 0);
  endtask

  task automatic t_load;
    wr(8'h20, 32'h0002_8000);
    wr(8'h1C, 32'hABCD_0001);
    rd_chk("R3 load lo", 8'h20, 32'h0002_8000);
    rd_chk("R2 hi field", 8'h1C, 32'h0000_0001);
  endtask

  task automatic t_sync;
    wr(8'h04, 32'h1);
    rd_chk("R5 lag 0", 8'h04, 0);
    ticks(1); rd_chk("R5 lag 1", 8'h04, 0);
    ticks(1); rd_chk("R5 lag 2", 8'h04, 0);
    ticks(1); rd_chk("R5 lag 3", 8'h04, 32'h1);
    rd_chk("R4 held while off", 8'h20, 32'h0002_8000);
    ticks(4);
    rd_chk("R4 four steps", 8'h20, 32'h0002_8004);
    wr(8'h20, 32'h0);
    rd_chk("R3 ignored running", 8'h20, 32'h0002_8004);
  endtask

  task automatic t_alarm;
    wr(8'h04, 32'h0);
    ticks(3);
    rd_chk("R5 stopped", 8'h04, 0);
    rd_chk("R4 ran during lag", 8'h20, 32'h0002_8007);
    wr(8'h1C, 32'h0);
    wr(8'h20, 32'h0002_FFFE);
    wr(8'h24, 32'd6);
    rd_chk("R6 target", 8'h24, 32'd6);
    wr(8'h04, 32'hF);
    ticks(3);
    rd_chk("R5 bit2 zero", 8'h04, 32'hB);
    rd_chk("R6 pre count", 8'h20, 32'h0002_FFFE);
    ticks(1); rd_chk("R6 not yet a", 8'h18, 0);
    ticks(1); rd_chk("R6 not yet b", 8'h18, 0);
    check("R8 irq quiet", {31'd0, irq}, 0);
    ticks(1); rd_chk("R6 fires", 8'h18, 1);
    check("R8 irq on", {31'd0, irq}, 1);
  endtask

  task automatic t_clear;
    wr(8'h18, 32'h0);
    rd_chk("R7 zero write keeps", 8'h18, 1);
    wr(8'h04, 32'h3);
    ticks(3);
    check("R8 wake off", {31'd0, irq}, 0);
    rd_chk("R7 still set", 8'h18, 1);
    wr(8'h18, 32'hFFFF_FFFF);
    rd_chk("R7 cleared", 8'h18, 0);
    wr(8'h04, 32'h1);
    ticks(3);
    wr(8'h18, 32'h1);
    ticks(2);
    rd_chk("R6 alarm disabled", 8'h18, 0);
    check("R8 irq off", {31'd0, irq}, 0);
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_spare();
    t_load();
    t_sync();
    t_alarm();
    t_clear();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule